// File: doc/BRIEF.md
# Free-running timer with pin-edge capture

This block is a 32-bit up-counter that runs on every clock while enabled. A latch freezes the count when a chosen transition arrives on an external pin. Software drives it through a small word-indexed register file. Through it software starts and presets the counter, sets a reload value used on overflow, picks which pin transitions qualify, and decides whether the pin is an input. It can also read the live and latched counts, inspect and clear the capture flag, enable the interrupt, and request a soft reset.

The pin passes through a two-stage synchronizer and a registered edge detector before it is qualified. When a qualifying transition arrives, the count is frozen into the capture register and a single capture flag is raised. The flag is raised whether or not the interrupt is enabled. While the flag is pending, the capture register is protected from later edges. Writing 1 to the flag through the masked-status register clears the flag and arms the latch again. One flag serves every edge mode, so software cannot tell a rising capture from a falling one.

The register interface is a plain single-cycle write strobe with a combinational read, because it carries control and status rather than a data stream. No valid/ready handshake exists and no back-pressure is possible: a write always lands on the next clock edge. The pin-drive enable and the interrupt are plain level outputs.

Top module: `cap_timer`

## Requirements
- R1: After rst_n is released, the count, control, reload and capture registers read 0, the capture flag is 0, irq is 0 and pin_oe is 0.
- R2: While control bit 0 (run) is 1, the count rises by one per clock; while it is 0 the count holds. A write to word 1 presets the count and takes priority over incrementing.
- R3: When the count is 0xFFFFFFFF and run is 1, the next value is the reload register (word 2) if control bit 1 (autoload) is 1, and 0 otherwise.
- R4: Control bits [3:2] select the capture edge: 0 none, 1 rising, 2 falling, 3 both. A qualifying edge copies the count into word 3 and sets the flag. With the counter running, the latched value is the count read in the cycle the pin changed, plus 2.
- R5: Word 4 bit 0 shows the capture flag whatever the enable is. Word 5 bit 0 reads the flag ANDed with word 6 bit 0 (interrupt enable).
- R6: While the flag is set, later qualifying edges leave word 3 unchanged.
- R7: Writing 1 to word 5 bit 0 clears the flag and re-arms capture. Writing word 4 has no effect on the flag.
- R8: Control bit 4 set to 1 makes the pin an output: pin_oe is 1 and no edge is captured.
- R9: irq is 1 exactly when the flag and the interrupt enable are both 1.
- R10: Writing 1 to word 7 bit 0 starts a soft reset. Word 7 bit 0 reads 1 for RST_CYCLES clocks, and afterwards every register is back at its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle it is high |
| reg_addr | input | 3 | Word index of the register |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| cap_pin | input | 1 | Asynchronous capture pin |
| pin_oe | output | 1 | Pin drive enable (control bit 4) |
| irq | output | 1 | Capture interrupt |

## Verification
A register write lands on the first clock edge after the strobe, and reads are combinational, so the bench writes at a falling edge and reads back at the next one. A pin change is first sampled one edge later. The flag and capture register update on the third rising edge after the change, and the latched value is then the pre-change count plus two. The bench therefore waits exactly three edges before reading. Counter steps and wrap values are checked after a counted number of edges from the write that started the run. The soft-reset busy bit is sampled both on its first cycle and after RST_CYCLES edges.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
  localparam int DW = 32;
  localparam int AW = 3;

  typedef enum logic [AW-1:0] {
    A_CTRL   = 3'd0,
    A_COUNT  = 3'd1,
    A_RELOAD = 3'd2,
    A_CAPT   = 3'd3,
    A_RAW    = 3'd4,
    A_MASKED = 3'd5,
    A_IEN    = 3'd6,
    A_SRST   = 3'd7
  } reg_addr_e;

  // control field positions; the edge field bits are decoded individually
  localparam int C_RUN  = 0;
  localparam int C_AUTO = 1;
  localparam int C_EDGE_LO = 2;
  localparam int C_DIR  = 4;
  localparam int CTRL_W = 5;

  typedef struct packed {
    logic       dir_out;
    logic [1:0] edge_sel;  // bit0 rising, bit1 falling
    logic       autoload;
    logic       run;
  } ctrl_t;
endpackage

// File: rtl/cap_timer_sync.sv
module cap_timer_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)   chain[0] <= 1'b0;
          else if (clr) chain[0] <= 1'b0;
          else          chain[0] <= pin;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n)   chain[g] <= 1'b0;
          else if (clr) chain[g] <= 1'b0;
          else          chain[g] <= chain[g-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)   prev <= 1'b0;
    else if (clr) prev <= 1'b0;
    else          prev <= chain[STAGES-1];

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/cap_timer_counter.sv
module cap_timer_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         run,
  input  logic         autoload,
  input  logic         load_we,
  input  logic [W-1:0] load_val,
  input  logic [W-1:0] reload,
  output logic [W-1:0] count
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                count <= '0;
    else if (clr)              count <= '0;
    else if (load_we)          count <= load_val;
    else if (run) begin
      if (count == TOP)        count <= autoload ? reload : '0;
      else                     count <= count + 1'b1;
    end

  // R2
  count_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load_we && !clr) |=> $stable(count));
  // R3
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load_we && !clr && count == TOP) |=>
      count == ($past(autoload) ? $past(reload) : '0));
endmodule

// File: rtl/cap_timer_capture.sv
module cap_timer_capture #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         hit,
  input  logic         ack,
  input  logic [W-1:0] count,
  output logic [W-1:0] cap_val,
  output logic         flag
);
  logic armed;
  assign armed = ~flag | ack;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cap_val <= '0;
      flag    <= 1'b0;
    end else if (clr) begin
      cap_val <= '0;
      flag    <= 1'b0;
    end else begin
      if (hit && armed) cap_val <= count;
      if (hit && armed) flag <= 1'b1;
      else if (ack)     flag <= 1'b0;
    end

  // R6
  hold_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack && !clr) |=> $stable(cap_val));
  // R4
  flag_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(hit));
endmodule

// File: rtl/cap_timer.sv
module cap_timer
  import cap_timer_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int RST_CYCLES  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          cap_pin,
  output logic          pin_oe,
  output logic          irq
);
  localparam int RCW = $clog2(RST_CYCLES + 1);

  ctrl_t          ctrl;
  logic [DW-1:0]  reload;
  logic           ien;
  logic [RCW-1:0] rst_cnt;
  logic           busy;
  logic [DW-1:0]  count, cap_val;
  logic           flag, rise, fall, hit, ack;
  logic           wr_ok;

  assign busy  = (rst_cnt != '0);
  assign wr_ok = reg_wr & ~busy;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                            rst_cnt <= '0;
    else if (wr_ok && reg_addr == A_SRST && reg_wdata[0])
                                           rst_cnt <= RCW'(RST_CYCLES);
    else if (busy)                         rst_cnt <= rst_cnt - 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
      ien    <= 1'b0;
    end else if (busy) begin
      ctrl   <= '0;
      reload <= '0;
      ien    <= 1'b0;
    end else if (wr_ok) begin
      case (reg_addr)
        A_CTRL:   ctrl   <= ctrl_t'(reg_wdata[CTRL_W-1:0]);
        A_RELOAD: reload <= reg_wdata;
        A_IEN:    ien    <= reg_wdata[0];
        default:  ;
      endcase
    end

  cap_timer_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(busy), .pin(cap_pin),
    .rise(rise), .fall(fall)
  );

  cap_timer_counter #(.W(DW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .clr(busy),
    .run(ctrl.run), .autoload(ctrl.autoload),
    .load_we(wr_ok && reg_addr == A_COUNT), .load_val(reg_wdata),
    .reload(reload), .count(count)
  );

  assign hit = ~ctrl.dir_out &
               ((ctrl.edge_sel[0] & rise) | (ctrl.edge_sel[1] & fall));
  assign ack = wr_ok && reg_addr == A_MASKED && reg_wdata[0];

  cap_timer_capture #(.W(DW)) u_cap (
    .clk(clk), .rst_n(rst_n), .clr(busy), .hit(hit), .ack(ack),
    .count(count), .cap_val(cap_val), .flag(flag)
  );

  assign pin_oe = ctrl.dir_out;
  assign irq    = flag & ien;

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL:   reg_rdata[CTRL_W-1:0] = ctrl;
      A_COUNT:  reg_rdata = count;
      A_RELOAD: reg_rdata = reload;
      A_CAPT:   reg_rdata = cap_val;
      A_RAW:    reg_rdata[0] = flag;
      A_MASKED: reg_rdata[0] = flag & ien;
      A_IEN:    reg_rdata[0] = ien;
      A_SRST:   reg_rdata[0] = busy;
      default:  ;
    endcase
  end

  // R10
  sreset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (ctrl == '0 && !flag));
  // R8
  dir_blocks_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl.dir_out && !flag) |=> !flag);
  // R9
  irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ien && !(wr_ok && reg_addr == A_IEN)) |=> !irq);
endmodule

// File: tb/cap_timer_bench.sv
module cap_timer_bench;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [2:0]  reg_addr = 0;
  logic [31:0] reg_wdata = 0;
  logic [31:0] reg_rdata;
  logic        cap_pin = 0;
  logic        pin_oe, irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  cap_timer u_cap_timer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_pin(cap_pin),
    .pin_oe(pin_oe), .irq(irq)
  );

  // {edge_sel[1:0], rising, dir_out, expect}
  localparam logic [4:0] VEC [0:7] = '{
    5'b00_1_0_0, 5'b01_1_0_1, 5'b01_0_0_0, 5'b10_0_0_1,
    5'b10_1_0_0, 5'b11_1_0_1, 5'b11_0_0_1, 5'b01_1_1_0
  };

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); @(negedge clk); end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    tick(1);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v, c;
    @(negedge clk); tick(2); rst_n = 1; tick(1);
    // R1 reset state
    rd(0, v); chk("R1 ctrl", v, 0);
    rd(1, v); chk("R1 count", v, 0);
    rd(3, v); chk("R1 capture", v, 0);
    rd(4, v); chk("R1 flag", v, 0);
    chk("R1 irq", {31'b0, irq}, 0);
    chk("R1 pin_oe", {31'b0, pin_oe}, 0);

    // table: edge modes and direction
    for (int i = 0; i < 8; i++) begin
      logic [1:0] m; logic r, d, e; logic [31:0] seed;
      {m, r, d, e} = VEC[i];
      seed = 32'h1000 + i * 17;
      wr(0, {27'b0, d, 2'b00, 2'b00});
      cap_pin = ~r; tick(4);
      wr(5, 1);
      wr(1, seed);
      wr(0, {27'b0, d, m, 2'b00});
      cap_pin = r; tick(3);
      rd(4, v); chk("R4 flag", v, {31'b0, e});
      if (e) begin rd(3, v); chk("R4 capture", v, seed); end
      if (d) chk("R8 pin_oe", {31'b0, pin_oe}, 1);
    end

    // R2 counting
    wr(0, 0); cap_pin = 0; tick(4); wr(5, 1);
    wr(1, 100); wr(0, 1);
    rd(1, v); chk("R2 start", v, 100);
    tick(5); rd(1, v); chk("R2 step", v, 105);
    wr(0, 0); rd(1, v); tick(3); rd(1, c); chk("R2 hold", c, v);
    // R3 wrap without and with autoload
    wr(2, 32'h10); wr(1, 32'hFFFF_FFFD); wr(0, 1); tick(3);
    rd(1, v); chk("R3 wrap0", v, 0);
    wr(0, 0); wr(1, 32'hFFFF_FFFD); wr(0, 3); tick(3);
    rd(1, v); chk("R3 reload", v, 32'h10);

    // R4 running capture, R5/R9 masking
    wr(0, 32'h5); wr(6, 0);
    rd(1, c); cap_pin = 1; tick(3);
    rd(3, v); chk("R4 running", v, c + 2);
    rd(4, v); chk("R5 raw", v, 1);
    rd(5, v); chk("R5 masked off", v, 0);
    chk("R9 irq off", {31'b0, irq}, 0);
    wr(6, 1);
    rd(5, v); chk("R5 masked on", v, 1);
    chk("R9 irq on", {31'b0, irq}, 1);
    // R6 pending blocks overwrite
    rd(3, c); cap_pin = 0; tick(4); cap_pin = 1; tick(4);
    rd(3, v); chk("R6 held", v, c);
    // R7 raw write ignored, masked clear re-arms
    wr(4, 1); rd(4, v); chk("R7 raw ignored", v, 1);
    wr(5, 1); rd(4, v); chk("R7 cleared", v, 0);
    chk("R9 irq cleared", {31'b0, irq}, 0);
    rd(1, c); cap_pin = 0; tick(4); cap_pin = 1; tick(3);
    rd(4, v); chk("R7 rearmed", v, 1);

    // R10 soft reset
    wr(7, 1);
    rd(7, v); chk("R10 busy", v, 1);
    tick(4);
    rd(7, v); chk("R10 done", v, 0);
    rd(0, v); chk("R10 ctrl", v, 0);
    rd(1, v); chk("R10 count", v, 0);
    rd(4, v); chk("R10 flag", v, 0);
    rd(6, v); chk("R10 ien", v, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule